// File: doc/BRIEF.md
# Leading Sign Bit Counter

This block measures how far a signed two's-complement word could be shifted left before its value changes. It counts the redundant sign bits: the run of consecutive bits just below the most significant bit that are equal to it. The count is placed in the upper half of the result word and the lower half is cleared, so a downstream stage can use the upper half directly as a shift amount.

The operand is presented together with a one-cycle valid strobe. On the rising clock edge where the strobe is high, the count is captured in an output register. A two-state output machine marks the result: state `ST_IDLE` means no new result is present, and state `ST_EMIT` means the result register was loaded on the last edge. The transition `IDLE->EMIT` (and `EMIT->EMIT`) is taken on any edge where the strobe is high. The transition `EMIT->IDLE` (and `IDLE->IDLE`) is taken on any edge where the strobe is low. The output valid flag is high exactly while the machine is in `ST_EMIT`. The operand is only read and is never altered. Normalising shifts and status flags belong to other blocks.

Top module: `sign_run_counter`

## Requirements
- R1: After reset, `out_valid` is 0, `out_result` is 0x00000000, and the machine is in `ST_IDLE`.
- R2: `out_valid` is 1 in the cycle after a cycle where `in_valid` was 1, and 0 in the cycle after a cycle where `in_valid` was 0.
- R3: Bits 31..16 of `out_result` hold the number of consecutive bits directly below bit 31 of the captured operand that equal bit 31. Bits 15..0 are always zero.
- R4: A positive operand of the form 2^k - 1 (k = 1..31) gives a count of 31 - k. For example, 0x00000001 gives 30 and 0x7FFFFFFF gives 0.
- R5: A negative operand with exactly k trailing zeros and ones above them (k = 0..31) gives 31 - k when k >= 1. For example, 0xFFFFFFFE gives 30, 0xFFFFFF00 gives 23, and 0x80000000 gives 0.
- R6: The operands 0x00000000 and 0xFFFFFFFF both give the maximum count of 31.
- R7: In a cycle where `in_valid` is 0, `out_result` keeps its value on the next edge, whatever `in_operand` carries.
- R8: When `in_valid` is high on consecutive edges, each edge captures the count of its own operand, and `out_valid` stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe; capture on this edge |
| in_operand | input | 32 | Signed operand to measure |
| out_valid | output | 1 | High for one cycle per captured operand |
| out_result | output | 32 | Count in bits 31..16, zero in bits 15..0 |

## Verification
Two things can happen in the same cycle. The marker for one result can be showing while the strobe for the next operand is already high, so the result register reloads while the machine stays in `ST_EMIT`. The bench provokes this by driving the strobe on two adjacent edges with operands whose counts differ. It then checks that the valid flag never drops and that the result changes from the first count to the second count exactly one edge later. A third sample, taken after the strobe falls, confirms that the flag drops while the second count is held even though the operand input changes.

// File: rtl/sign_run_pkg.sv
package sign_run_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;
endpackage

// File: rtl/sign_run_diff.sv
// Marks every position where a bit differs from the bit directly above it.
module sign_run_diff #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-2:0] edge_vec
);
    for (genvar g = 0; g < DATA_W - 1; g++) begin : g_pair
        assign edge_vec[g] = operand[g+1] ^ operand[g];
    end
endmodule

// File: rtl/sign_run_prio.sv
// Returns the index of the highest set bit of the request vector.
module sign_run_prio #(
    parameter int REQ_W = 31,
    localparam int IDX_W = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
    input  logic [REQ_W-1:0] req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < REQ_W; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sign_run_fsm.sv
module sign_run_fsm
    import sign_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic mark
);
    emit_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = strobe ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = strobe ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: mark = 1'b0;
            ST_EMIT: mark = 1'b1;
            default: mark = 1'b0;
        endcase
    end
endmodule

// File: rtl/sign_run_counter.sv
module sign_run_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int EDGE_W  = DATA_W - 1;
    localparam int IDX_W   = (EDGE_W > 1) ? $clog2(EDGE_W) : 1;
    localparam int MAX_RUN = DATA_W - 1;
    localparam int TOP_POS = DATA_W - 2;

    logic [EDGE_W-1:0] edge_vec;
    logic              edge_hit;
    logic [IDX_W-1:0]  edge_idx;
    logic [HALF_W-1:0] run_cnt;
    logic [HALF_W-1:0] cnt_q;

    sign_run_diff #(.DATA_W(DATA_W)) u_diff (
        .operand  (in_operand),
        .edge_vec (edge_vec)
    );

    sign_run_prio #(.REQ_W(EDGE_W)) u_prio (
        .req (edge_vec),
        .hit (edge_hit),
        .idx (edge_idx)
    );

    always_comb begin
        if (edge_hit) run_cnt = HALF_W'(TOP_POS) - HALF_W'(edge_idx);
        else          run_cnt = HALF_W'(MAX_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_valid) cnt_q <= run_cnt;
    end

    sign_run_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (in_valid),
        .mark   (out_valid)
    );

    assign out_result = {cnt_q, {(DATA_W - HALF_W){1'b0}}};
endmodule

// File: rtl/sign_run_counter_chk.sv
module sign_run_counter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_operand,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    localparam int HALF_W = DATA_W / 2;

    AST_LOW_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[HALF_W-1:0] == '0); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[DATA_W-1:HALF_W] <= HALF_W'(DATA_W - 1)); // R3
    AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R7
    AST_FLAT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_operand == '0 || in_operand == '1))
        |=> out_result[DATA_W-1:HALF_W] == HALF_W'(DATA_W - 1)); // R6
    AST_TOP_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_operand[DATA_W-1] != in_operand[DATA_W-2]))
        |=> out_result[DATA_W-1:HALF_W] == '0); // R4
endmodule

bind sign_run_counter sign_run_counter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/sign_run_counter_bench.sv
module sign_run_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sign_run_counter u_sign_run_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Independent model: count the bits below the sign bit that match it.
    function automatic logic [31:0] model(input logic [31:0] v);
        int n = 0;
        for (int b = 30; b >= 0; b--) begin
            if (v[b] != v[31]) break;
            n++;
        end
        return {16'(n), 16'h0000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one operand for a single edge, then check at the next falling edge.
    task automatic single_shot(input string req, input logic [31:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_operand = v;
        @(negedge clk);
        in_valid = 1'b0; in_operand = ~v;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_result, model(v));
    endtask

    task automatic t_reset();
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", out_result, 32'd0);
    endtask

    task automatic t_examples();
        single_shot("R4 0x00000001", 32'h0000_0001);
        check("R4 literal 30", out_result, 32'd30 << 16);
        single_shot("R4 0x7FFFFFFF", 32'h7FFF_FFFF);
        check("R4 literal 0", out_result, 32'd0);
        single_shot("R5 0xFFFFFFFE", 32'hFFFF_FFFE);
        check("R5 literal 30", out_result, 32'd30 << 16);
        single_shot("R5 0xFFFFFF00", 32'hFFFF_FF00);
        check("R5 literal 23", out_result, 32'd23 << 16);
        single_shot("R5 0x80000000", 32'h8000_0000);
        check("R5 literal 0", out_result, 32'd0);
    endtask

    task automatic t_positive_sweep();
        for (int k = 1; k <= 31; k++) begin
            logic [31:0] v = (32'd1 << k) - 32'd1;
            single_shot("R4 sweep", v);
            check("R4 formula", out_result, 32'(31 - k) << 16);
        end
    endtask

    task automatic t_negative_sweep();
        for (int k = 1; k <= 31; k++) begin
            logic [31:0] v = 32'hFFFF_FFFF << k;
            single_shot("R5 sweep", v);
            check("R5 formula", out_result, 32'(31 - k) << 16);
        end
    endtask

    task automatic t_flat();
        single_shot("R6 zero", 32'h0000_0000);
        check("R6 zero max", out_result, 32'd31 << 16);
        single_shot("R6 ones", 32'hFFFF_FFFF);
        check("R6 ones max", out_result, 32'd31 << 16);
    endtask

    task automatic t_mixed();
        single_shot("R3 0x00A5A5A5", 32'h00A5_A5A5);
        single_shot("R3 0xFF5A5A5A", 32'hFF5A_5A5A);
        single_shot("R3 0x12345678", 32'h1234_5678);
        single_shot("R3 0xC0000001", 32'hC000_0001);
    endtask

    task automatic t_hold();
        single_shot("R7 setup", 32'h0000_00FF);
        for (int i = 0; i < 3; i++) begin
            in_operand = 32'h4000_0000 >> i;
            @(negedge clk);
            check("R7 held result", out_result, model(32'h0000_00FF));
            check("R7 valid low", {31'd0, out_valid}, 32'd0);
        end
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; in_operand = 32'h0000_0003;
        @(negedge clk);
        check("R8 first valid", {31'd0, out_valid}, 32'd1);
        check("R8 first result", out_result, 32'd29 << 16);
        in_operand = 32'hFFF0_0000;
        @(negedge clk);
        in_valid = 1'b0; in_operand = 32'h0000_0000;
        check("R8 second valid", {31'd0, out_valid}, 32'd1);
        check("R8 second result", out_result, 32'd11 << 16);
        @(negedge clk);
        check("R2 valid falls", {31'd0, out_valid}, 32'd0);
        check("R8 second held", out_result, 32'd11 << 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_positive_sweep();
        t_negative_sweep();
        t_flat();
        t_mixed();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule